// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port

This block gives a processor two byte-wide general-purpose ports, called A and B. Each port has a data latch and a direction latch. Software reaches them over a small synchronous bus with a register address, a write strobe, write data and combinational read data. Toward the pads, each port drives one level per bit and takes the sampled pad levels back in. The pad drivers and the peripherals outside are not part of this block.

A direction bit set to 1 makes its pin an output that carries the latched data bit. A direction bit of 0 makes the pin an input, and that pin is driven high, like a weak pull-up. The outside world can still pull such a pin low. A read of a data register returns the internally driven level, wired-AND with what the pad reports. Port B differs from port A in one way: its output-configured bits take no account of the pad. The pad levels pass through two flip-flops before any read uses them.

The address bus carries one more bit above the two register-select bits. When that bit is 1, the access belongs to a neighbouring function, so this block neither stores the write nor returns data for it.

Top module: `pport_top`

## Requirements
- R1: A synchronous active-low reset clears both data latches and both direction latches to 0x00. As a result, both pin-drive vectors are 0xFF out of reset.
- R2: When bus_addr[2] is 0, bus_addr[1:0] selects the register: 0 is port A data, 1 is port A direction, 2 is port B data, 3 is port B direction. When bus_addr[2] is 1, a write changes no register and a read returns 0x00.
- R3: Each bit of a port's pin-drive vector equals (data bit OR NOT direction bit). The vector takes its new value at the same rising edge that stores a write to that port's data or direction latch.
- R4: A read of port A data returns (data OR NOT direction) AND the synchronized port A pad levels.
- R5: A read of port B data returns (data OR NOT direction) AND (synchronized port B pad levels OR direction). A bit configured as an output therefore reads back its latched value whatever the pad shows.
- R6: A read of a direction register returns exactly the value last written to it.
- R7: A change on a pad input first shows in readback after the second rising edge that follows it. It has not yet shown after the first edge.
- R8: With bus_wr low, no register changes, whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Bit 2 = 0 selects this block; bits 1:0 pick the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pa_pin_out | output | 8 | Level driven toward the port A pads |
| pa_pin_in | input | 8 | Asynchronous port A pad levels |
| pb_pin_out | output | 8 | Level driven toward the port B pads |
| pb_pin_in | input | 8 | Asynchronous port B pad levels |

## Verification
The pin-drive vectors and latch contents change at the rising edge that takes a write. The bench drives each write on a falling edge and checks the result at the next falling edge. Read data is combinational in the address, so each read is checked 1 ns after the address changes. A pad change needs two rising edges before it shows. The bench therefore applies the pad change on a falling edge, checks that the old value is still returned one edge later, and checks for the new value after the second edge. In the general readback scenarios, the bench waits three edges after any pad change so that the synchronizer has settled.

// File: rtl/pport_pkg.sv
// Package: shared register-select encoding for the parallel port block.
// Assumes the two low address bits pick one of four registers.
package pport_pkg;

    typedef enum logic [1:0] {
        SEL_A_DATA = 2'd0,
        SEL_A_DIR  = 2'd1,
        SEL_B_DATA = 2'd2,
        SEL_B_DIR  = 2'd3
    } pport_sel_e;

endpackage

// File: rtl/pport_sync.sv
// Module: pport_sync
// Two-stage synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent: no multi-bit coherence is promised.
// Both stages reset to all ones, the idle level of an input pin with a pull-up.
module pport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_cnt;   // edges since reset, saturating; used by the checker only

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    // Count edges since reset so the latency check starts only once history exists.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2)
            warm_cnt <= warm_cnt + 2'd1;
    end

    assign q_o = stage2_q;

    // R7: the output is the input from exactly two edges earlier.
    assert_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 2'd2) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/pport_lane.sv
// Module: pport_lane
// One port: a data latch, a direction latch, the pin-drive level and the
// data readback. OUT_MASKS_PIN chooses the readback variant:
//   0: drive AND pad
//   1: drive AND (pad OR direction), so output bits ignore the pad.
// Assumes pin_sync_i is already synchronous to clk.
module pport_lane #(
    parameter int W             = 8,
    parameter bit OUT_MASKS_PIN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_we_i,
    input  logic         dir_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] pin_sync_i,
    output logic [W-1:0] pin_drive_o,
    output logic [W-1:0] data_rd_o,
    output logic [W-1:0] dir_rd_o
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_seen;

    // Data latch: loaded by a write to this port's data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (data_we_i)
            data_q <= wdata_i;
    end

    // Direction latch: loaded by a write to this port's direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (dir_we_i)
            dir_q <= wdata_i;
    end

    // Pin level: outputs carry data, inputs float high.
    always_comb begin
        pin_drive_o = data_q | ~dir_q;
    end

    // Pad view used for readback, chosen by the port variant.
    generate
        if (OUT_MASKS_PIN) begin : g_masked
            always_comb pin_seen = pin_sync_i | dir_q;
        end else begin : g_plain
            always_comb pin_seen = pin_sync_i;
        end
    endgenerate

    // Readback: wired-AND of the driven level with the pad view.
    always_comb begin
        data_rd_o = pin_drive_o & pin_seen;
        dir_rd_o  = dir_q;
    end

    // R1: reset empties both latches.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && dir_q == '0));

    // R6: a direction write is stored as given.
    assert_dir_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we_i |=> (dir_rd_o == $past(wdata_i)));

    // R8: without a strobe, the latches hold.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_we_i && !dir_we_i) |=> ($stable(data_q) && $stable(dir_q)));

    // R3: a data write reaches the pins of output bits at the same edge.
    assert_drive_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we_i && !dir_we_i) |=> ((pin_drive_o & dir_q) == ($past(wdata_i) & dir_q)));

endmodule

// File: rtl/pport_top.sv
// Module: pport_top
// Two parallel ports on a byte-wide bus. bus_addr[IO_BIT] must be 0 for an
// access to belong to this block. The low two address bits select a register
// (see pport_pkg). Read data is combinational; writes take effect at the edge.
module pport_top #(
    parameter int W      = 8,
    parameter int ADDR_W = 3,
    parameter int IO_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      pa_pin_out,
    input  logic [W-1:0]      pa_pin_in,
    output logic [W-1:0]      pb_pin_out,
    input  logic [W-1:0]      pb_pin_in
);
    import pport_pkg::*;

    localparam int NPORT = 2;

    logic                 io_hit;
    pport_sel_e           sel;
    logic [NPORT-1:0]     data_we;
    logic [NPORT-1:0]     dir_we;
    logic [NPORT-1:0][W-1:0] pin_raw;
    logic [NPORT-1:0][W-1:0] pin_sync;
    logic [NPORT-1:0][W-1:0] pin_drive;
    logic [NPORT-1:0][W-1:0] data_rd;
    logic [NPORT-1:0][W-1:0] dir_rd;

    // Address decode: block hit and register select.
    always_comb begin
        io_hit = (bus_addr[IO_BIT] == 1'b0);
        sel    = pport_sel_e'(bus_addr[1:0]);
    end

    // Write enables per port; bit 1 of the select picks the port, bit 0 the latch.
    always_comb begin
        data_we = '0;
        dir_we  = '0;
        if (bus_wr && io_hit) begin
            data_we[bus_addr[1]] = (bus_addr[0] == 1'b0);
            dir_we[bus_addr[1]]  = (bus_addr[0] == 1'b1);
        end
    end

    assign pin_raw[0] = pa_pin_in;
    assign pin_raw[1] = pb_pin_in;

    // One synchronizer and one lane per port; port B masks its output bits.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            pport_sync #(.W(W)) sync_i (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (pin_raw[p]),
                .q_o   (pin_sync[p])
            );
            pport_lane #(.W(W), .OUT_MASKS_PIN(p == 1)) lane_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .data_we_i   (data_we[p]),
                .dir_we_i    (dir_we[p]),
                .wdata_i     (bus_wdata),
                .pin_sync_i  (pin_sync[p]),
                .pin_drive_o (pin_drive[p]),
                .data_rd_o   (data_rd[p]),
                .dir_rd_o    (dir_rd[p])
            );
        end
    endgenerate

    assign pa_pin_out = pin_drive[0];
    assign pb_pin_out = pin_drive[1];

    // Read mux; accesses outside this block read zero.
    always_comb begin
        bus_rdata = '0;
        if (io_hit) begin
            unique case (sel)
                SEL_A_DATA: bus_rdata = data_rd[0];
                SEL_A_DIR:  bus_rdata = dir_rd[0];
                SEL_B_DATA: bus_rdata = data_rd[1];
                SEL_B_DIR:  bus_rdata = dir_rd[1];
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R2: a write aimed at the neighbouring function leaves both ports unchanged.
    assert_foreign_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[IO_BIT]) |=> ($stable(pa_pin_out) && $stable(pb_pin_out)));

    // R2: such a read returns zero.
    assert_foreign_rd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[IO_BIT] |-> (bus_rdata == '0));

    // R5: port B bits set as outputs read back their drive level.
    assert_b_out_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(2)) |-> ((bus_rdata & dir_rd[1]) == (pb_pin_out & dir_rd[1])));

endmodule

// File: tb/pport_top_tb_top.sv
// Bench: directed scenarios for pport_top. Each task checks its own results
// against a shadow model of the four registers kept here.
module pport_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_pin_out, pb_pin_out;
    logic [7:0] pa_pin_in = 8'hFF;
    logic [7:0] pb_pin_in = 8'hFF;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_oa = 8'h00, m_da = 8'h00, m_ob = 8'h00, m_db = 8'h00;

    always #5 clk = ~clk;

    pport_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_pin_out(pa_pin_out), .pa_pin_in(pa_pin_in),
        .pb_pin_out(pb_pin_out), .pb_pin_in(pb_pin_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_a();
        return (m_oa | ~m_da) & pa_pin_in;
    endfunction
    function automatic logic [7:0] exp_b();
        return (m_ob | ~m_db) & (pb_pin_in | m_db);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[2] == 1'b0) begin
            case (a[1:0])
                2'd0: m_oa = d;
                2'd1: m_da = d;
                2'd2: m_ob = d;
                default: m_db = d;
            endcase
        end
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pins(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        pa_pin_in = a; pb_pin_in = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 pa drive", pa_pin_out, 8'hFF);
        check("R1 pb drive", pb_pin_out, 8'hFF);
        rd(3'd1, "R1 A dir", 8'h00);
        rd(3'd3, "R1 B dir", 8'h00);
        rd(3'd0, "R1 A data", 8'hFF);
        rd(3'd2, "R1 B data", 8'hFF);
    endtask

    task automatic t_map_and_dir();
        wr(3'd1, 8'h5A); wr(3'd3, 8'hC3);
        rd(3'd1, "R2 R6 A dir", 8'h5A);
        rd(3'd3, "R2 R6 B dir", 8'hC3);
        wr(3'd1, 8'hF0);
        rd(3'd1, "R6 A dir rewrite", 8'hF0);
        rd(3'd3, "R2 B dir untouched", 8'hC3);
    endtask

    task automatic t_drive();
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h0F; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; m_oa = 8'h0F;
        check("R3 A drive same edge", pa_pin_out, (m_oa | ~m_da));
        wr(3'd2, 8'h81);
        check("R3 B drive", pb_pin_out, (m_ob | ~m_db));
        wr(3'd1, 8'hFF);
        check("R3 A all out", pa_pin_out, 8'h0F);
        wr(3'd1, 8'h00);
        check("R3 A all in", pa_pin_out, 8'hFF);
    endtask

    task automatic t_a_read();
        wr(3'd1, 8'hF0); wr(3'd0, 8'h30);
        pins(8'hFF, 8'hFF);
        rd(3'd0, "R4 A pins high", exp_a());
        pins(8'h96, 8'hFF);
        rd(3'd0, "R4 A pins pulled", exp_a());
        pins(8'h00, 8'hFF);
        rd(3'd0, "R4 A all low", 8'h00);
    endtask

    task automatic t_b_read();
        wr(3'd3, 8'h0F); wr(3'd2, 8'h05);
        pins(8'hFF, 8'h00);
        rd(3'd2, "R5 B pins low", exp_b());
        check("R5 B out bits", bus_rdata & 8'h0F, 8'h05);
        pins(8'hFF, 8'hA5);
        rd(3'd2, "R5 B mixed", exp_b());
        pins(8'hFF, 8'hFF);
        rd(3'd2, "R5 B pins high", exp_b());
    endtask

    task automatic t_sync();
        wr(3'd1, 8'h00);
        pins(8'hFF, 8'hFF);
        bus_addr = 3'd0;
        @(negedge clk);
        pa_pin_in = 8'h3C;
        @(negedge clk);
        #1 check("R7 one edge old", bus_rdata, 8'hFF);
        @(negedge clk);
        #1 check("R7 two edges new", bus_rdata, 8'h3C);
        pa_pin_in = 8'hFF;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_foreign();
        wr(3'd4, 8'hAA); wr(3'd5, 8'h55); wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
        rd(3'd1, "R2 A dir kept", m_da);
        rd(3'd3, "R2 B dir kept", m_db);
        check("R2 pa kept", pa_pin_out, (m_oa | ~m_da));
        check("R2 pb kept", pb_pin_out, (m_ob | ~m_db));
        rd(3'd4, "R2 foreign read", 8'h00);
        rd(3'd7, "R2 foreign read hi", 8'h00);
    endtask

    task automatic t_no_strobe();
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            bus_addr = 3'(a); bus_wdata = 8'h69; bus_wr = 1'b0;
        end
        @(negedge clk);
        rd(3'd1, "R8 A dir", m_da);
        rd(3'd3, "R8 B dir", m_db);
        check("R8 pa", pa_pin_out, (m_oa | ~m_da));
        check("R8 pb", pb_pin_out, (m_ob | ~m_db));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_and_dir();
        t_drive();
        t_a_read();
        t_b_read();
        t_sync();
        t_foreign();
        t_no_strobe();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule